// File: doc/BRIEF.md
# Sticky Status Flag Register

This block holds the 16-bit error and alarm status word of a sensor device. Detection logic elsewhere drives one condition line per flag. A sample strobe marks each sampling cycle. A clear pulse arrives when the command register is written with its flag-clear bit set. The register has no write path. Software reads it one byte at a time through a byte-addressed read port, and a full-word copy is also provided for local use.

Two kinds of flag share the word. Six event flags are sticky. Each one records a condition seen at any strobe and holds it until a clear pulse. Two supply-range flags are live. They copy their condition at every strobe, so they drop by themselves once the supply returns to range. A clear does not hide a fault that is still present. The flag returns at the next strobe that sees the condition. If that strobe falls in the same cycle as the clear, the flag stays set.

Top module: `sticky_status_reg`

## Requirements
- R1: Sticky flag positions are fixed. Capture-full is bit 12, alarm 2 is bit 9, alarm 1 is bit 8, self-test error is bit 5, serial link failure is bit 3 and nonvolatile update failure is bit 2. Each flag is set on the clock edge where `sample_i` is high and its condition input is high.
- R2: Bit 1 (supply over range) and bit 0 (supply under range) take the level of `supply_hi_i` and `supply_lo_i` on every edge where `sample_i` is high. They return to 0 without any clear.
- R3: A sticky flag that is set stays set through strobes whose condition is low, as long as `clear_i` is low.
- R4: On an edge with `clear_i` high and `sample_i` low, every sticky flag goes to 0. Bits 1 and 0 keep their value.
- R5: On an edge with both `clear_i` and `sample_i` high, a sticky flag whose condition is high ends set, and any other sticky flag ends cleared. After a clear, a condition that persists sets its flag again at the next strobe.
- R6: With `sample_i` low, the status word changes only through a clear. A condition is sampled as a level at strobe edges only. A condition that rises between strobes is recorded at the next strobe if it is still high then.
- R7: Bits 15:13, 11:10, 7:6 and 4 always read 0.
- R8: While `rst_n` is low the status word is 0x0000.
- R9: `rd_data_o` is combinational. It gives status bits 7:0 when `rd_addr_i` is 0x3C, bits 15:8 when it is 0x3D, and 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sampling-cycle strobe |
| clear_i | input | 1 | One-cycle clear pulse from the command register decode |
| capfull_i | input | 1 | Capture buffers full condition |
| alarm2_i | input | 1 | Alarm 2 active condition |
| alarm1_i | input | 1 | Alarm 1 active condition |
| selftest_err_i | input | 1 | Self-test diagnostic error condition |
| link_fail_i | input | 1 | Serial communication failure condition |
| nv_fail_i | input | 1 | Nonvolatile update failure condition |
| supply_hi_i | input | 1 | Supply above upper limit |
| supply_lo_i | input | 1 | Supply below lower limit |
| rd_addr_i | input | 8 | Byte read address |
| rd_data_o | output | 8 | Byte read data |
| status_o | output | 16 | Full status word |

## Verification
Flag updates from a strobe or a clear appear exactly one clock edge after the cycle in which the pulse is high. Read data follows the address and the current word in the same cycle. The bench changes inputs on the falling edge and advances its reference model right after the rising edge. It compares on the next falling edge, where the registered word already holds the effect of the previous cycle and the byte read reflects the address just applied. Directed sequences cover these cases with explicit expected words: a clear alone, a clear together with a persisting condition, a condition that falls between strobes, and out-of-range read addresses. A long random run then compares every cycle against the model.

// File: rtl/sts_pkg.sv
package sts_pkg;

  localparam int STS_W     = 16;
  localparam int NUM_LATCH = 6;
  localparam int NUM_LIVE  = 2;

  // bit positions of the sticky flags, index order matches the top's condition vector
  localparam int LATCH_POS [NUM_LATCH] = '{12, 9, 8, 5, 3, 2};
  // bit positions of the live supply flags
  localparam int LIVE_POS  [NUM_LIVE]  = '{1, 0};

  function automatic logic [STS_W-1:0] latch_mask();
    logic [STS_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LATCH; i++) m[LATCH_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [STS_W-1:0] live_mask();
    logic [STS_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LIVE; i++) m[LIVE_POS[i]] = 1'b1;
    return m;
  endfunction

  // next value of a sticky flag: clear first, then the sampled condition wins
  function automatic logic sticky_next(logic cur, logic smp, logic clr, logic cond);
    logic kept;
    kept = cur & ~clr;
    return smp ? (kept | cond) : kept;
  endfunction

  // byte selection of the read port
  function automatic logic [7:0] byte_pick(logic [STS_W-1:0] word, logic sel_lo, logic sel_hi);
    if (sel_lo)      return word[7:0];
    else if (sel_hi) return word[15:8];
    else             return 8'h00;
  endfunction

endpackage

// File: rtl/sts_latch_cell.sv
module sts_latch_cell
  import sts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic clr_i,
  input  logic cond_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb flag_d = sticky_next(flag_q, smp_i, clr_i, cond_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/sts_live_cell.sv
module sts_live_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic cond_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (smp_i) flag_q <= cond_i;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/sts_read_mux.sv
module sts_read_mux
  import sts_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h3C
) (
  input  logic [STS_W-1:0]  word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);

  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

  logic sel_lo;
  logic sel_hi;

  assign sel_lo = (addr_i == BASE_ADDR);
  assign sel_hi = (addr_i == HI_ADDR);
  assign data_o = byte_pick(word_i, sel_lo, sel_hi);

endmodule

// File: rtl/sticky_status_reg.sv
module sticky_status_reg
  import sts_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              clear_i,
  input  logic              capfull_i,
  input  logic              alarm2_i,
  input  logic              alarm1_i,
  input  logic              selftest_err_i,
  input  logic              link_fail_i,
  input  logic              nv_fail_i,
  input  logic              supply_hi_i,
  input  logic              supply_lo_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [STS_W-1:0]  status_o
);

  // named events for the checker
  logic                 smp_evt;
  logic                 clr_evt;
  logic [NUM_LATCH-1:0] latch_cond;
  logic [NUM_LIVE-1:0]  live_cond;
  logic [NUM_LATCH-1:0] latch_q;
  logic [NUM_LIVE-1:0]  live_q;
  logic [STS_W-1:0]     cond_word;
  logic [STS_W-1:0]     status_w;

  assign smp_evt = sample_i;
  assign clr_evt = clear_i;

  // order follows LATCH_POS
  assign latch_cond = {nv_fail_i, link_fail_i, selftest_err_i, alarm1_i, alarm2_i, capfull_i};
  // order follows LIVE_POS
  assign live_cond  = {supply_lo_i, supply_hi_i};

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    sts_latch_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp_evt),
      .clr_i  (clr_evt),
      .cond_i (latch_cond[g]),
      .flag_o (latch_q[g])
    );
  end

  for (genvar g = 0; g < NUM_LIVE; g++) begin : g_live
    sts_live_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp_evt),
      .cond_i (live_cond[g]),
      .flag_o (live_q[g])
    );
  end

  always_comb begin
    status_w  = '0;
    cond_word = '0;
    for (int i = 0; i < NUM_LATCH; i++) begin
      status_w[LATCH_POS[i]]  = latch_q[i];
      cond_word[LATCH_POS[i]] = latch_cond[i];
    end
    for (int i = 0; i < NUM_LIVE; i++) begin
      status_w[LIVE_POS[i]]  = live_q[i];
      cond_word[LIVE_POS[i]] = live_cond[i];
    end
  end

  assign status_o = status_w;

  sts_read_mux #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_rd (
    .word_i (status_w),
    .addr_i (rd_addr_i),
    .data_o (rd_data_o)
  );

endmodule

// File: rtl/sts_chk.sv
module sts_chk
  import sts_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h3C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_evt,
  input logic              clr_evt,
  input logic [STS_W-1:0]  cond_word,
  input logic              supply_hi_i,
  input logic              supply_lo_i,
  input logic [STS_W-1:0]  status_o,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o
);

  localparam logic [STS_W-1:0]  LMASK   = latch_mask();
  localparam logic [STS_W-1:0]  VMASK   = live_mask();
  localparam logic [STS_W-1:0]  UMASK   = ~(LMASK | VMASK);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & UMASK) == '0);

  a_r2_live_follow: assert property (@(posedge clk) disable iff (!rst_n)
    smp_evt |=> status_o[1:0] == $past({supply_hi_i, supply_lo_i}));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_evt && !clr_evt) |=> $stable(status_o));

  a_r4_clear_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !smp_evt) |=> ((status_o & LMASK) == '0) &&
                              ((status_o & VMASK) == ($past(status_o) & VMASK)));

  a_r5_cond_wins: assert property (@(posedge clk) disable iff (!rst_n)
    smp_evt |=> (status_o & $past(cond_word) & LMASK) == ($past(cond_word) & LMASK));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_evt && !clr_evt) |=> (status_o & $past(status_o) & LMASK) == ($past(status_o) & LMASK));

  a_r9_read_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == BASE_ADDR) |-> rd_data_o == status_o[7:0]);

  a_r9_read_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == HI_ADDR) |-> rd_data_o == status_o[15:8]);

  a_r9_read_other: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i != BASE_ADDR && rd_addr_i != HI_ADDR) |-> rd_data_o == 8'h00);

endmodule

bind sticky_status_reg sts_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_evt     (smp_evt),
  .clr_evt     (clr_evt),
  .cond_word   (cond_word),
  .supply_hi_i (supply_hi_i),
  .supply_lo_i (supply_lo_i),
  .status_o    (status_o),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/tb_sticky_status_reg.sv
`timescale 1ns/1ps
module tb_sticky_status_reg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_i, clear_i;
  logic [15:0] cond;
  logic [7:0]  rd_addr_i;
  logic [7:0]  rd_data_o;
  logic [15:0] status_o;

  int          vectors = 0;
  int          fails   = 0;
  bit          done    = 0;
  logic [15:0] m;
  string       tag;
  int          lpos[$] = '{12, 9, 8, 5, 3, 2};

  always #2.5 clk = ~clk;

  sticky_status_reg dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_i       (sample_i),
    .clear_i        (clear_i),
    .capfull_i      (cond[12]),
    .alarm2_i       (cond[9]),
    .alarm1_i       (cond[8]),
    .selftest_err_i (cond[5]),
    .link_fail_i    (cond[3]),
    .nv_fail_i      (cond[2]),
    .supply_hi_i    (cond[1]),
    .supply_lo_i    (cond[0]),
    .rd_addr_i      (rd_addr_i),
    .rd_data_o      (rd_data_o),
    .status_o       (status_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_exp(logic [7:0] a, logic [15:0] w);
    if (a == 8'h3C) return w[7:0];
    if (a == 8'h3D) return w[15:8];
    return 8'h00;
  endfunction

  // reference model: one rising edge
  task automatic model_edge();
    if (!rst_n) m = 16'h0000;
    else begin
      foreach (lpos[k]) begin
        if (sample_i)     m[lpos[k]] = (m[lpos[k]] & ~clear_i) | cond[lpos[k]];
        else if (clear_i) m[lpos[k]] = 1'b0;
      end
      if (sample_i) begin
        m[1] = cond[1];
        m[0] = cond[0];
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, status_o, m);
    chk("R7", status_o & 16'hECD0, 16'h0000);
    chk("R9", {8'h00, rd_data_o}, {8'h00, rd_exp(rd_addr_i, m)});
  endtask

  task automatic drive(logic s, logic c, logic [15:0] cv);
    sample_i = s;
    clear_i  = c;
    cond     = cv;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m = 16'h0000;
    rst_n = 1'b0; rd_addr_i = 8'h3C;
    drive(1'b1, 1'b0, 16'hFFFF);
    tag = "R8";
    for (int i = 0; i < 3; i++) cycle();
    chk("R8", status_o, 16'h0000);
    rst_n = 1'b1;

    // R1: alarm 1 sets bit 8
    tag = "R1"; drive(1, 0, 16'h0100); cycle();
    chk("R1", status_o, 16'h0100);
    // R3: held through strobes with condition low
    tag = "R3"; drive(1, 0, 16'h0000); cycle(); cycle();
    chk("R3", status_o, 16'h0100);
    // R6: condition without strobe has no effect
    tag = "R6"; drive(0, 0, 16'h1000); cycle(); cycle(); cycle();
    chk("R6", status_o, 16'h0100);
    drive(1, 0, 16'h0000); cycle();
    chk("R6", status_o, 16'h0100);
    drive(0, 0, 16'h1000); cycle(); cycle();
    drive(1, 0, 16'h1000); cycle();
    chk("R6", status_o, 16'h1100);
    // R2: live supply bit
    tag = "R2"; drive(1, 0, 16'h0002); cycle();
    chk("R2", status_o, 16'h1102);
    // R4: clear alone drops sticky flags, keeps live
    tag = "R4"; drive(0, 1, 16'h0000); cycle();
    chk("R4", status_o, 16'h0002);
    tag = "R2"; drive(1, 0, 16'h0000); cycle();
    chk("R2", status_o, 16'h0000);
    // R5: clear with persisting condition
    tag = "R5"; drive(1, 0, 16'h0200); cycle();
    chk("R5", status_o, 16'h0200);
    drive(1, 1, 16'h0220); cycle();
    chk("R5", status_o, 16'h0220);
    drive(0, 1, 16'h0200); cycle();
    chk("R5", status_o, 16'h0000);
    drive(1, 0, 16'h0200); cycle();
    chk("R5", status_o, 16'h0200);
    // R9: byte reads
    tag = "R9"; drive(1, 0, 16'h000D); cycle();
    chk("R9", status_o, 16'h020D);
    drive(0, 0, 16'h0000);
    rd_addr_i = 8'h3C; #1 chk("R9", {8'h00, rd_data_o}, 16'h000D);
    rd_addr_i = 8'h3D; #1 chk("R9", {8'h00, rd_data_o}, 16'h0002);
    rd_addr_i = 8'h3E; #1 chk("R9", {8'h00, rd_data_o}, 16'h0000);
    rd_addr_i = 8'h3B; #1 chk("R9", {8'h00, rd_data_o}, 16'h0000);
    cycle();

    // random run against the model
    tag = "R1/R3/R4/R5";
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 3) == 0, ($urandom % 7) == 0, 16'($urandom) & ($urandom % 2 ? 16'hFFFF : 16'h0000));
      rd_addr_i = 8'h3A + 8'($urandom % 5);
      cycle();
    end

    // R8: reset mid-run
    tag = "R8"; rst_n = 1'b0; drive(0, 0, 16'h0000); cycle();
    chk("R8", status_o, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule